// File: doc/BRIEF.md
# Programmable Baud Rate Generator

This block derives one output clock from a selectable source by integer division. A 32-bit control word, loaded through a single-cycle write strobe and always visible on a read-back port, selects the source, the divide count, an optional fixed divide-by-16 stage, an output enable and a counter-hold bit. The source is either the internal reference (the block's own clock, one tick per cycle) or one of two external clock pins. Each external pin goes through a synchronizer, and a rising edge on it counts as one tick.

Two pairs of external clock pins reach every instance. The instance index parameter selects which pair the two external source codes refer to. A helper output gives the total divide ratio that the stored control word programs, so surrounding logic can compute the output rate without decoding the fields itself. Changes to the count and to the divide-by-16 choice are applied only at the end of the current output period. The output therefore never shows a truncated pulse.

Top module: `brg_gen`

## Requirements
- R1: After reset the control word reads 0 and the output is low. A write strobe stores the 32-bit write data on that clock edge, and the read-back port returns the stored word unchanged until the next write.
- R2: The divide count N sits in control bits 12:1. The output period is N+1 source ticks, for every N from 0 to 4095. With the internal reference one tick is one clock cycle.
- R3: Within each period the output is high for ceil((N+1)/2) ticks and low for floor((N+1)/2) ticks. When N is 0 the output stays high while it is enabled.
- R4: When control bit 0 is set, a divide-by-16 stage sits in front of the counter. The period becomes 16·(N+1) ticks and each phase is 16 times longer.
- R5: Control bits 15:14 choose the source. Code 0 is the internal reference, code 1 is the first pin of the selected pair, code 2 is the second pin, and code 3 behaves as code 0.
- R6: Instance indices 1, 2, 5 and 6 use pin pair A. Indices 3, 4, 7 and 8 use pin pair B.
- R7: While control bit 16 (enable) is clear the output is low. The stored word is kept and the counters keep running, so re-enabling resumes the output at the phase it would have had anyway.
- R8: While control bit 17 (hold) is set the output is low and both counters stay at the start of a period. If hold is cleared by a write on edge k, the output is low after edge k, goes high after edge k+1 and then runs full-length phases.
- R9: A new count or prescaler choice written mid-period takes effect only at the next period boundary. The period in progress completes at its old length.
- R10: The ratio output is (N+1)·16 when bit 0 is set and N+1 otherwise, taken from the stored control word. Its range runs from 1 to 65536.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock and internal reference source |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wr | input | 1 | Control word write strobe |
| cfg_wdata | input | 32 | Control word write data |
| cfg_rdata | output | 32 | Stored control word |
| clk_pair_a | input | 2 | External clock pins, pair A |
| clk_pair_b | input | 2 | External clock pins, pair B |
| brg_out | output | 1 | Generated clock |
| ratio_o | output | 17 | Total programmed divide ratio |

## Verification
The bench sweeps the count through every small value and odd/even split, and also tries the largest unprescaled count and several prescaled counts. A design with an off-by-one in the N+1 encoding, or with the duty split the wrong way round, gives a wrong high or low length there. It drives two differently parameterized instances from four pins at distinct rates. A swapped pin pair or a mis-mapped code 3 therefore shows up as a wrong period. The enable and hold tests compare output samples cycle by cycle against an ideal phase sequence. A design that froze its counters when disabled, or that released hold mid-period, lands on the wrong phase. A mid-period count change is checked for a completed old-length period followed at once by the new length, which catches designs that switch immediately and truncate a pulse.

// File: rtl/brg_pkg.sv
package brg_pkg;
  localparam int CFG_W     = 32;
  localparam int CNT_LSB   = 1;
  localparam int CNT_W     = 12;
  localparam int PRE_BIT   = 0;
  localparam int SRC_LSB   = 14;
  localparam int EN_BIT    = 16;
  localparam int HOLD_BIT  = 17;
  localparam int PRE_DIV   = 16;
  localparam int PRE_SH    = $clog2(PRE_DIV);
  localparam int RATIO_W   = CNT_W + PRE_SH + 1;

  typedef enum logic [1:0] {
    SRC_REF   = 2'd0,
    SRC_PIN0  = 2'd1,
    SRC_PIN1  = 2'd2,
    SRC_SPARE = 2'd3
  } src_sel_e;

  typedef struct packed {
    logic             hold;
    logic             en;
    src_sel_e         src;
    logic             pre;
    logic [CNT_W-1:0] cnt;
  } brg_ctl_t;
endpackage

// File: rtl/brg_src_sel.sv
module brg_src_sel
  import brg_pkg::*;
#(
  parameter int SYNC = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] pins,
  input  src_sel_e   sel,
  output logic       tick_o
);
  logic [1:0] rise_w;

  for (genvar g = 0; g < 2; g++) begin : g_pin
    logic [SYNC:0] ch_q;
    logic [SYNC:0] ch_d;

    always_comb begin
      ch_d = {ch_q[SYNC-1:0], pins[g]};
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) ch_q <= '0;
      else        ch_q <= ch_d;
    end

    assign rise_w[g] = ch_q[SYNC-1] & ~ch_q[SYNC];
  end

  always_comb begin
    unique case (sel)
      SRC_PIN0: tick_o = rise_w[0];
      SRC_PIN1: tick_o = rise_w[1];
      default:  tick_o = 1'b1;
    endcase
  end
endmodule

// File: rtl/brg_prescale.sv
module brg_prescale #(
  parameter int DIV = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic bypass,
  input  logic tick_i,
  output logic tick_o
);
  localparam int PW = $clog2(DIV);

  logic [PW-1:0] pcnt_q;
  logic [PW-1:0] pcnt_d;
  logic          last;

  assign last = (pcnt_q == PW'(DIV - 1));

  always_comb begin
    pcnt_d = pcnt_q;
    if (clr || bypass) begin
      pcnt_d = '0;
    end else if (tick_i) begin
      pcnt_d = last ? '0 : pcnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pcnt_q <= '0;
    else        pcnt_q <= pcnt_d;
  end

  assign tick_o = bypass ? tick_i : (tick_i & last);
endmodule

// File: rtl/brg_divider.sv
module brg_divider #(
  parameter int CW = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          hold,
  input  logic          en,
  input  logic          tick_i,
  input  logic [CW-1:0] cfg_lim,
  input  logic          cfg_pre,
  output logic [CW-1:0] cnt_o,
  output logic [CW-1:0] lim_o,
  output logic          pre_o,
  output logic          out_o
);
  logic [CW-1:0] cnt_q, cnt_d;
  logic [CW-1:0] lim_q, lim_d;
  logic          pre_q, pre_d;
  logic          out_q, out_d;
  logic          wrap;

  assign wrap = tick_i && (cnt_q == lim_q);

  always_comb begin
    cnt_d = cnt_q;
    lim_d = lim_q;
    pre_d = pre_q;
    if (hold) begin
      cnt_d = '0;
      lim_d = cfg_lim;
      pre_d = cfg_pre;
    end else if (wrap) begin
      cnt_d = '0;
      lim_d = cfg_lim;
      pre_d = cfg_pre;
    end else if (tick_i) begin
      cnt_d = cnt_q + 1'b1;
    end
    out_d = en && !hold && (cnt_q <= (lim_q >> 1));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      lim_q <= '0;
      pre_q <= 1'b0;
      out_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      lim_q <= lim_d;
      pre_q <= pre_d;
      out_q <= out_d;
    end
  end

  assign cnt_o = cnt_q;
  assign lim_o = lim_q;
  assign pre_o = pre_q;
  assign out_o = out_q;
endmodule

// File: rtl/brg_gen.sv
module brg_gen
  import brg_pkg::*;
#(
  parameter int INST_IDX = 1,
  parameter int SYNC     = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cfg_wr,
  input  logic [CFG_W-1:0]   cfg_wdata,
  output logic [CFG_W-1:0]   cfg_rdata,
  input  logic [1:0]         clk_pair_a,
  input  logic [1:0]         clk_pair_b,
  output logic               brg_out,
  output logic [RATIO_W-1:0] ratio_o
);
  localparam bit USE_B = (((INST_IDX - 1) / 2) % 2) == 1;

  logic [CFG_W-1:0] cfg_q, cfg_d;
  brg_ctl_t         ctl;
  logic [1:0]       pins_sel;
  logic             src_tick;
  logic             pre_tick;
  logic             pre_act;
  logic [CNT_W-1:0] div_cnt;
  logic [CNT_W-1:0] div_lim;
  logic [RATIO_W-1:0] base;

  always_comb begin
    cfg_d = cfg_q;
    if (cfg_wr) cfg_d = cfg_wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cfg_q <= '0;
    else        cfg_q <= cfg_d;
  end

  assign ctl.hold = cfg_q[HOLD_BIT];
  assign ctl.en   = cfg_q[EN_BIT];
  assign ctl.src  = src_sel_e'(cfg_q[SRC_LSB +: 2]);
  assign ctl.pre  = cfg_q[PRE_BIT];
  assign ctl.cnt  = cfg_q[CNT_LSB +: CNT_W];

  assign pins_sel = USE_B ? clk_pair_b : clk_pair_a;

  brg_src_sel #(.SYNC(SYNC)) u_src (
    .clk    (clk),
    .rst_n  (rst_n),
    .pins   (pins_sel),
    .sel    (ctl.src),
    .tick_o (src_tick)
  );

  brg_prescale #(.DIV(PRE_DIV)) u_pre (
    .clk    (clk),
    .rst_n  (rst_n),
    .clr    (ctl.hold),
    .bypass (!pre_act),
    .tick_i (src_tick),
    .tick_o (pre_tick)
  );

  brg_divider #(.CW(CNT_W)) u_div (
    .clk     (clk),
    .rst_n   (rst_n),
    .hold    (ctl.hold),
    .en      (ctl.en),
    .tick_i  (pre_tick),
    .cfg_lim (ctl.cnt),
    .cfg_pre (ctl.pre),
    .cnt_o   (div_cnt),
    .lim_o   (div_lim),
    .pre_o   (pre_act),
    .out_o   (brg_out)
  );

  always_comb begin
    base    = RATIO_W'(ctl.cnt) + RATIO_W'(1);
    ratio_o = ctl.pre ? (base << PRE_SH) : base;
  end

  assign cfg_rdata = cfg_q;
endmodule

// File: rtl/brg_checker.sv
module brg_checker #(
  parameter int CW = 12,
  parameter int RW = 17
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cfg_wr,
  input logic [31:0]   cfg_wdata,
  input logic [31:0]   cfg_rdata,
  input logic          brg_out,
  input logic [RW-1:0] ratio_o,
  input logic [CW-1:0] div_cnt,
  input logic [CW-1:0] div_lim
);
  assert_cfg_keep_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_wr |=> $stable(cfg_rdata));

  assert_cfg_load_R1: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_wr |=> (cfg_rdata == $past(cfg_wdata)));

  assert_no_overflow_R2: assert property (@(posedge clk) disable iff (!rst_n)
    div_cnt <= div_lim);

  assert_prescale_mult_R4: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_rdata[0] |-> (ratio_o[3:0] == 4'd0));

  assert_gate_low_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(cfg_rdata[16]) |-> !brg_out);

  assert_hold_low_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $past(cfg_rdata[17]) |-> !brg_out);

  assert_boundary_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(div_lim) |-> (div_cnt == '0));

  assert_ratio_range_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (ratio_o != '0) && (cfg_rdata[0] || (ratio_o <= RW'(4096))));
endmodule

bind brg_gen brg_checker #(.CW(brg_pkg::CNT_W), .RW(brg_pkg::RATIO_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .cfg_wr    (cfg_wr),
  .cfg_wdata (cfg_wdata),
  .cfg_rdata (cfg_rdata),
  .brg_out   (brg_out),
  .ratio_o   (ratio_o),
  .div_cnt   (div_cnt),
  .div_lim   (div_lim)
);

// File: tb/tb_brg_gen.sv
module tb_brg_gen;
  localparam int CLK_PERIOD = 10;

  logic        clk;
  logic        rst_n;
  logic        cfg_wr;
  logic [31:0] cfg_wdata;
  logic [31:0] rd_b, rd_a;
  logic [1:0]  pair_a, pair_b;
  logic        out_b, out_a;
  logic [16:0] ratio_b, ratio_a;

  int total = 0;
  int bad   = 0;
  int ph    = 0;
  bit done  = 0;

  brg_gen #(.INST_IDX(3)) dut (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_wdata(cfg_wdata),
    .cfg_rdata(rd_b), .clk_pair_a(pair_a), .clk_pair_b(pair_b),
    .brg_out(out_b), .ratio_o(ratio_b));

  brg_gen #(.INST_IDX(6)) dut_alt (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_wdata(cfg_wdata),
    .cfg_rdata(rd_a), .clk_pair_a(pair_a), .clk_pair_b(pair_b),
    .brg_out(out_a), .ratio_o(ratio_a));

  initial begin
    clk = 1'b0;
    forever #(CLK_PERIOD / 2) clk = ~clk;
  end

  // pins: B0 period 4, B1 period 8, A0 period 6, A1 period 10
  initial begin
    pair_a = 2'b00;
    pair_b = 2'b00;
    forever begin
      @(negedge clk);
      ph++;
      pair_b[0] = (ph % 4) < 2;
      pair_b[1] = (ph % 8) < 4;
      pair_a[0] = (ph % 6) < 3;
      pair_a[1] = (ph % 10) < 5;
    end
  end

  function automatic logic [31:0] mk(int n, bit pre, int src, bit en, bit hold);
    logic [31:0] v;
    v        = '0;
    v[12:1]  = n[11:0];
    v[0]     = pre;
    v[15:14] = src[1:0];
    v[16]    = en;
    v[17]    = hold;
    return v;
  endfunction

  function automatic bit outv(int which);
    return (which == 0) ? out_b : out_a;
  endfunction

  task automatic chk(bit ok, string req, string what, int act, int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic write_cfg(logic [31:0] v);
    @(negedge clk);
    cfg_wr    = 1'b1;
    cfg_wdata = v;
    @(negedge clk);
    cfg_wr    = 1'b0;
  endtask

  task automatic wait_rise(int which, output bit ok);
    bit prev, cur;
    ok   = 1'b0;
    prev = outv(which);
    for (int t = 0; t < 20000; t++) begin
      @(negedge clk);
      cur = outv(which);
      if (!prev && cur) begin
        ok = 1'b1;
        break;
      end
      prev = cur;
    end
  endtask

  task automatic measure(int which, output int hi, output int lo, output bit ok);
    bit r;
    hi = 0;
    lo = 0;
    ok = 1'b0;
    wait_rise(which, r);
    if (!r) return;
    hi = 1;
    for (int t = 0; t < 70000; t++) begin
      @(negedge clk);
      if (outv(which)) hi++;
      else break;
    end
    lo = 1;
    for (int t = 0; t < 70000; t++) begin
      @(negedge clk);
      if (!outv(which)) lo++;
      else begin
        ok = 1'b1;
        break;
      end
    end
  endtask

  task automatic run_period(int which, int n, bit pre, int src, int tick, string req);
    int hi, lo, r, eh, el, mul;
    bit ok, allhi;
    r   = n + 1;
    mul = (pre ? 16 : 1) * tick;
    eh  = ((r + 1) / 2) * mul;
    el  = (r / 2) * mul;
    write_cfg(mk(n, pre, src, 1'b1, 1'b0));
    if (n == 0) begin
      repeat (40) @(negedge clk);
      allhi = 1'b1;
      for (int t = 0; t < 20; t++) begin
        @(negedge clk);
        if (!outv(which)) allhi = 1'b0;
      end
      chk(allhi, req, $sformatf("steady high n=0 src=%0d", src), allhi, 1);
      return;
    end
    measure(which, hi, lo, ok);
    measure(which, hi, lo, ok);
    chk(ok && hi == eh, req, $sformatf("high n=%0d pre=%0d src=%0d inst=%0d", n, pre, src, which), hi, eh);
    chk(ok && lo == el, req, $sformatf("low n=%0d pre=%0d src=%0d inst=%0d", n, pre, src, which), lo, el);
  endtask

  // watchdog
  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 190000, 0);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    bit ok, lowok, seqok;
    int m;
    cfg_wr    = 1'b0;
    cfg_wdata = '0;
    rst_n     = 1'b0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 / R10 reset state
    chk(rd_b == 32'd0, "R1", "reset cfg", rd_b, 0);
    chk(out_b == 1'b0, "R1", "reset out", out_b, 0);
    chk(ratio_b == 17'd1, "R10", "reset ratio", ratio_b, 1);

    // R1 write and readback
    write_cfg(32'hFFFC_2A55 & ~(32'h3 << 16));
    chk(rd_b == (32'hFFFC_2A55 & ~(32'h3 << 16)), "R1", "readback", rd_b, 32'hFFFC_2A55 & ~(32'h3 << 16));
    repeat (5) @(negedge clk);
    chk(rd_b == (32'hFFFC_2A55 & ~(32'h3 << 16)), "R1", "readback kept", rd_b, 32'hFFFC_2A55 & ~(32'h3 << 16));

    // R2 R3 sweep, internal reference
    for (int n = 0; n < 16; n++) begin
      run_period(0, n, 1'b0, 0, 1, "R2/R3");
      chk(ratio_b == 17'(n + 1), "R10", $sformatf("ratio n=%0d", n), ratio_b, n + 1);
    end
    // R2 largest unprescaled count
    run_period(0, 4095, 1'b0, 0, 1, "R2");
    chk(ratio_b == 17'd4096, "R10", "ratio 4096", ratio_b, 4096);

    // R4 prescaler
    for (int n = 0; n < 5; n++) begin
      run_period(0, n, 1'b1, 0, 1, "R4");
      chk(ratio_b == 17'((n + 1) * 16), "R10", $sformatf("ratio pre n=%0d", n), ratio_b, (n + 1) * 16);
    end
    run_period(0, 300, 1'b1, 0, 1, "R4");
    write_cfg(mk(4095, 1'b1, 0, 1'b0, 1'b0));
    chk(ratio_b == 17'd65536, "R10", "ratio max", ratio_b, 65536);

    // R5 R6 source select and pin pair per instance
    run_period(0, 2, 1'b0, 1, 4, "R5/R6");
    run_period(0, 2, 1'b0, 2, 8, "R5/R6");
    run_period(1, 2, 1'b0, 1, 6, "R5/R6");
    run_period(1, 2, 1'b0, 2, 10, "R5/R6");
    run_period(0, 3, 1'b0, 3, 1, "R5");
    run_period(1, 4, 1'b0, 3, 1, "R5");
    run_period(0, 3, 1'b1, 1, 4, "R4/R5");

    // R7 enable gating with running counters (R=8, high 4)
    write_cfg(mk(7, 1'b0, 0, 1'b1, 1'b0));
    wait_rise(0, ok);
    wait_rise(0, ok);
    chk(ok, "R7", "rise before disable", ok, 1);
    cfg_wdata = mk(7, 1'b0, 0, 1'b0, 1'b0);
    cfg_wr    = 1'b1;
    @(negedge clk);
    cfg_wr = 1'b0;
    lowok  = 1'b1;
    for (int k = 2; k <= 30; k++) begin
      @(negedge clk);
      if (out_b) lowok = 1'b0;
    end
    chk(lowok, "R7", "low while disabled", lowok, 1);
    chk(rd_b == mk(7, 1'b0, 0, 1'b0, 1'b0), "R7", "config kept", rd_b, mk(7, 1'b0, 0, 1'b0, 1'b0));
    cfg_wdata = mk(7, 1'b0, 0, 1'b1, 1'b0);
    cfg_wr    = 1'b1;
    @(negedge clk);
    cfg_wr = 1'b0;
    chk(out_b == 1'b0, "R7", "low one cycle after enable write", out_b, 0);
    seqok = 1'b1;
    for (int k = 32; k < 48; k++) begin
      @(negedge clk);
      if (out_b != ((k % 8) < 4)) seqok = 1'b0;
    end
    chk(seqok, "R7", "phase continues after re-enable", seqok, 1);

    // R8 hold bit (R=6, high 3)
    write_cfg(mk(5, 1'b0, 0, 1'b1, 1'b1));
    lowok = 1'b1;
    for (int k = 0; k < 30; k++) begin
      @(negedge clk);
      if (out_b) lowok = 1'b0;
    end
    chk(lowok, "R8", "low while held", lowok, 1);
    cfg_wdata = mk(5, 1'b0, 0, 1'b1, 1'b0);
    cfg_wr    = 1'b1;
    @(negedge clk);
    cfg_wr = 1'b0;
    chk(out_b == 1'b0, "R8", "low right after release", out_b, 0);
    seqok = 1'b1;
    for (int k = 2; k < 14; k++) begin
      @(negedge clk);
      if (out_b != (((k - 2) % 6) < 3)) seqok = 1'b0;
    end
    chk(seqok, "R8", "full phases from release", seqok, 1);

    // R9 count change at boundary: R=10 then R=4
    write_cfg(mk(9, 1'b0, 0, 1'b1, 1'b0));
    wait_rise(0, ok);
    wait_rise(0, ok);
    cfg_wdata = mk(3, 1'b0, 0, 1'b1, 1'b0);
    cfg_wr    = 1'b1;
    seqok = out_b;
    m = 0;
    for (int k = 1; k < 16; k++) begin
      @(negedge clk);
      cfg_wr = 1'b0;
      m = k;
      if (k < 10) begin
        if (out_b != (k < 5)) seqok = 1'b0;
      end else begin
        if (out_b != (((k - 10) % 4) < 2)) seqok = 1'b0;
      end
    end
    chk(seqok, "R9", $sformatf("old period completes then new, through %0d", m), seqok, 1);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule